// File: doc/BRIEF.md
# Soft-Start and Fault Sequencer

This block sequences the start-up of a switching regulator controller. It runs on the converter's oscillator clock. Three digital comparator flags come in: supply healthy, enable (the compensation node is above its shutdown level) and feedback under-voltage. Every flag passes through a two-flop synchroniser before the control logic sees it.

Once the supply is healthy and enable is high, the sequencer waits a fixed start-up delay. It then turns on the gate drivers and drives a reference code to an external reference DAC. That code climbs as a staircase from zero to the final regulation level, and at the top the block raises a done flag. After that, an under-voltage report latches the converter off. Both gates go off and the output floats. Only a supply drop or an enable cycle releases this latch, and either one restarts the whole delay and ramp.

All pins are plain level signals. No pin is a data stream, so there is no handshake and no back-pressure.

Top module: `sseq_top`

## Requirements
- R1: While reset is held, and after it is released with all flags low, `ref_code` is 0, `gate_en` is 0 and `ss_done` is 0.
- R2: The sequence starts only when `supply_ok` and `enable` are both high. With only `supply_ok` high, `gate_en` stays 0 indefinitely.
- R3: Suppose both flags become high before clock edge 1. Then `gate_en` is 0 after edge 1026 and rises to 1 after edge 1027. This is three edges of input latency plus a delay of DELAY_CYCLES = 1024 clocks.
- R4: `ref_code` is an unsigned 7-bit count, 0 to 64, and one LSB is 18.75 mV of reference. During the ramp it starts at 0 and increments by exactly 1 every STEP_CYCLES = 16 clocks. It is n after edge 1027+16n, and it never skips a value or decreases while the gates are on.
- R5: `ref_code` reaches 64 after edge 2051 and then holds there. `ss_done` is 1 exactly when the block sits at code 64 with the gates on.
- R6: `uv_flag` is ignored before `ss_done` is set. A flag held high through the delay and the ramp does not stop the ramp from completing.
- R7: Suppose `uv_flag` is high while `ss_done` is 1. Three edges later the fault latch sets: `gate_en`, `ss_done` and `ref_code` all go to 0. They stay there after `uv_flag` returns low.
- R8: Suppose `enable` goes low in any state. Three edges later `gate_en`, `ss_done` and `ref_code` are 0.
- R9: Suppose `supply_ok` goes low in any state. Three edges later `gate_en`, `ss_done` and `ref_code` are 0.
- R10: Only an enable cycle or a supply cycle clears the fault latch. When the flags are restored, the full timing of R3 to R5 repeats.
- R11: `ref_code` never exceeds 64, and it is 0 whenever `gate_en` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Oscillator clock; one edge per switching cycle |
| rst_n | input | 1 | Asynchronous active-low reset |
| supply_ok | input | 1 | Supply above its rising threshold (comparator has hysteresis) |
| enable | input | 1 | Compensation node above its shutdown level |
| uv_flag | input | 1 | Feedback below half of the reference |
| ref_code | output | 7 | Reference DAC code, 18.75 mV per LSB, final value 64 |
| gate_en | output | 1 | Gate drivers allowed to switch; 0 means both gates off |
| ss_done | output | 1 | Ramp finished and reference at final value |

## Verification
Every flag passes through two synchroniser flops and then the state register. So an input change that lands between edges shows on the outputs after the third following edge, not the second. The bench samples on the falling clock edge and checks both of those cycles.

Timing is counted from the enable event. The gates open after edge 1027, each code step lands 16 edges after the previous one, and done appears after edge 2051. A table of edge counts and expected outputs holds these points, and the bench checks the cycle just before each transition as well as the cycle of the transition. The fault, shutdown and supply-loss responses are checked at exactly +2 (unchanged) and +3 (off) edges from the stimulus.

// File: rtl/sseq_pkg.sv
package sseq_pkg;
  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_WAIT  = 3'd1,
    ST_RAMP  = 3'd2,
    ST_RUN   = 3'd3,
    ST_FAULT = 3'd4
  } sseq_state_t;
endpackage

// File: rtl/sseq_sync.sv
module sseq_sync #(
  parameter int W = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta <= '0;
      q    <= '0;
    end else begin
      meta <= d;
      q    <= meta;
    end
  end
endmodule

// File: rtl/sseq_timer.sv
module sseq_timer #(
  parameter int TW = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          inc,
  output logic [TW-1:0] cnt
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   cnt <= '0;
    else if (clr) cnt <= '0;
    else if (inc) cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/sseq_ramp.sv
module sseq_ramp #(
  parameter int CW    = 7,
  parameter int FINAL = 64
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          step,
  output logic [CW-1:0] code
);
  localparam logic [CW-1:0] TOP = CW'(FINAL);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                       code <= '0;
    else if (clr)                     code <= '0;
    else if (step && code != TOP)     code <= code + 1'b1;
  end
endmodule

// File: rtl/sseq_ctrl.sv
module sseq_ctrl
  import sseq_pkg::*;
#(
  parameter int TW           = 10,
  parameter int CW           = 7,
  parameter int DELAY_CYCLES = 1024,
  parameter int STEP_CYCLES  = 16,
  parameter int STEPS        = 64
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          supply_s,
  input  logic          en_s,
  input  logic          uv_s,
  input  logic [TW-1:0] cnt,
  input  logic [CW-1:0] code,
  output sseq_state_t   state,
  output logic          timer_clr,
  output logic          timer_inc,
  output logic          ramp_clr,
  output logic          ramp_step
);
  localparam logic [TW-1:0] DLY_LAST  = TW'(DELAY_CYCLES - 1);
  localparam logic [TW-1:0] STEP_LAST = TW'(STEP_CYCLES - 1);
  localparam logic [CW-1:0] PRE_TOP   = CW'(STEPS - 1);

  sseq_state_t state_n;

  assign ramp_step = (state == ST_RAMP) && (cnt == STEP_LAST);

  always_comb begin
    state_n = state;
    if (!supply_s || !en_s) begin
      state_n = ST_IDLE;
    end else begin
      case (state)
        ST_IDLE:  state_n = ST_WAIT;
        ST_WAIT:  if (cnt == DLY_LAST) state_n = ST_RAMP;
        ST_RAMP:  if (ramp_step && code == PRE_TOP) state_n = ST_RUN;
        ST_RUN:   if (uv_s) state_n = ST_FAULT;
        ST_FAULT: state_n = ST_FAULT;
        default:  state_n = ST_IDLE;
      endcase
    end
  end

  assign timer_clr = (state_n != state) || ramp_step;
  assign timer_inc = (state == ST_WAIT) || (state == ST_RAMP);
  assign ramp_clr  = (state_n == ST_IDLE) || (state_n == ST_WAIT) ||
                     (state_n == ST_FAULT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= ST_IDLE;
    else        state <= state_n;
  end
endmodule

// File: rtl/sseq_top.sv
module sseq_top
  import sseq_pkg::*;
#(
  parameter int DELAY_CYCLES = 1024,
  parameter int STEP_CYCLES  = 16,
  parameter int STEPS        = 64,
  localparam int CW          = $clog2(STEPS + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          supply_ok,
  input  logic          enable,
  input  logic          uv_flag,
  output logic [CW-1:0] ref_code,
  output logic          gate_en,
  output logic          ss_done
);
  localparam int LONGEST = (DELAY_CYCLES > STEP_CYCLES) ? DELAY_CYCLES : STEP_CYCLES;
  localparam int TW      = $clog2(LONGEST) + 1;

  logic [2:0]    flags_s;
  logic [TW-1:0] cnt;
  logic          timer_clr, timer_inc, ramp_clr, ramp_step;
  sseq_state_t   state;

  sseq_sync #(.W(3)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     ({supply_ok, enable, uv_flag}),
    .q     (flags_s)
  );

  sseq_timer #(.TW(TW)) u_timer (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (timer_clr),
    .inc   (timer_inc),
    .cnt   (cnt)
  );

  sseq_ramp #(.CW(CW), .FINAL(STEPS)) u_ramp (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (ramp_clr),
    .step  (ramp_step),
    .code  (ref_code)
  );

  sseq_ctrl #(
    .TW(TW), .CW(CW), .DELAY_CYCLES(DELAY_CYCLES),
    .STEP_CYCLES(STEP_CYCLES), .STEPS(STEPS)
  ) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .supply_s  (flags_s[2]),
    .en_s      (flags_s[1]),
    .uv_s      (flags_s[0]),
    .cnt       (cnt),
    .code      (ref_code),
    .state     (state),
    .timer_clr (timer_clr),
    .timer_inc (timer_inc),
    .ramp_clr  (ramp_clr),
    .ramp_step (ramp_step)
  );

  assign gate_en = (state == ST_RAMP) || (state == ST_RUN);
  assign ss_done = (state == ST_RUN);
endmodule

// File: rtl/sseq_chk.sv
module sseq_chk #(
  parameter int CW    = 7,
  parameter int FINAL = 64
) (
  input logic          clk,
  input logic          rst_n,
  input logic          supply_ok,
  input logic          enable,
  input logic [CW-1:0] ref_code,
  input logic          gate_en,
  input logic          ss_done
);
  localparam logic [CW-1:0] TOP = CW'(FINAL);

  p_code_max_r11: assert property (@(posedge clk) disable iff (!rst_n)
    ref_code <= TOP);

  p_off_zero_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !gate_en |-> ref_code == '0);

  p_done_top_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ss_done |-> (gate_en && ref_code == TOP));

  p_step_one_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (gate_en && $past(gate_en)) |->
      (ref_code == $past(ref_code) || ref_code == $past(ref_code) + 1'b1));

  p_en_off_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(enable, 3) |-> !gate_en);

  p_sup_off_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(supply_ok, 3) |-> (!gate_en && !ss_done));
endmodule

bind sseq_top sseq_chk #(.CW(CW), .FINAL(STEPS)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .supply_ok (supply_ok),
  .enable    (enable),
  .ref_code  (ref_code),
  .gate_en   (gate_en),
  .ss_done   (ss_done)
);

// File: tb/sim_sseq_top.sv
module sim_sseq_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       supply_ok = 1'b0;
  logic       enable = 1'b0;
  logic       uv_flag = 1'b0;
  logic [6:0] ref_code;
  logic       gate_en;
  logic       ss_done;

  int n_chk = 0;
  int n_bad = 0;
  int since = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  sseq_top u0 (
    .clk(clk), .rst_n(rst_n), .supply_ok(supply_ok), .enable(enable),
    .uv_flag(uv_flag), .ref_code(ref_code), .gate_en(gate_en), .ss_done(ss_done)
  );

  // {edges after enable [11:0], code [6:0], gate, done}
  localparam int NV = 12;
  localparam logic [20:0] VEC [0:NV-1] = '{
    {12'd2,    7'd0,  1'b0, 1'b0},
    {12'd3,    7'd0,  1'b0, 1'b0},
    {12'd1026, 7'd0,  1'b0, 1'b0},
    {12'd1027, 7'd0,  1'b1, 1'b0},
    {12'd1042, 7'd0,  1'b1, 1'b0},
    {12'd1043, 7'd1,  1'b1, 1'b0},
    {12'd1059, 7'd2,  1'b1, 1'b0},
    {12'd1539, 7'd32, 1'b1, 1'b0},
    {12'd2050, 7'd63, 1'b1, 1'b0},
    {12'd2051, 7'd64, 1'b1, 1'b1},
    {12'd2100, 7'd64, 1'b1, 1'b1},
    {12'd2400, 7'd64, 1'b1, 1'b1}
  };

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic chk_out(input string req, input int c, input int g, input int d);
    chk({req, " code"}, ref_code, c);
    chk({req, " gate"}, gate_en, g);
    chk({req, " done"}, ss_done, d);
  endtask

  task automatic mark();
    since = 0;
  endtask

  task automatic adv_to(input int t);
    repeat (t - since) @(posedge clk);
    since = t;
    @(negedge clk);
  endtask

  task automatic walk_table(input string req);
    for (int i = 0; i < NV; i++) begin
      adv_to(int'(VEC[i][20:9]));
      chk_out(req, int'(VEC[i][8:2]), int'(VEC[i][1]), int'(VEC[i][0]));
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk_out("R1 in reset", 0, 0, 0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    chk_out("R1 after reset", 0, 0, 0);

    // R2: supply alone starts nothing
    supply_ok = 1'b1; mark();
    adv_to(1200);
    chk_out("R2 supply only", 0, 0, 0);

    // R3 R4 R5: full timed sequence from table
    enable = 1'b1; mark();
    walk_table("R3/R4/R5 table");

    // R8: enable drop in RUN
    enable = 1'b0; mark();
    adv_to(2); chk("R8 enable +2 gate", gate_en, 1);
    adv_to(3); chk_out("R8 enable +3", 0, 0, 0);
    adv_to(40); chk_out("R8 stays off", 0, 0, 0);

    // R6 then R7: uv held through whole ramp, trips only after done
    uv_flag = 1'b1;
    enable = 1'b1; mark();
    adv_to(1027); chk("R6 uv ignored, gate opens", gate_en, 1);
    adv_to(1539); chk("R6 uv ignored mid ramp", ref_code, 32);
    adv_to(2051); chk_out("R6 ramp completes", 64, 1, 1);
    adv_to(2052); chk_out("R7 fault latched", 0, 0, 0);
    uv_flag = 1'b0; mark();
    adv_to(300); chk_out("R7 fault holds after uv clears", 0, 0, 0);

    // R10: enable cycle clears fault, full restart
    enable = 1'b0; mark(); adv_to(10);
    enable = 1'b1; mark();
    adv_to(1026); chk("R10 enable restart delay", gate_en, 0);
    adv_to(1027); chk("R10 enable restart gate", gate_en, 1);
    adv_to(2051); chk_out("R10 enable restart done", 64, 1, 1);

    // R9: supply loss mid ramp... first fault again then supply cycle
    uv_flag = 1'b1; mark();
    adv_to(3); chk_out("R7 second fault", 0, 0, 0);
    uv_flag = 1'b0;
    supply_ok = 1'b0; mark();
    adv_to(20); chk_out("R9 supply low", 0, 0, 0);
    supply_ok = 1'b1; mark();
    adv_to(1026); chk("R10 supply restart delay", gate_en, 0);
    adv_to(1027); chk("R10 supply restart gate", gate_en, 1);
    adv_to(1200); chk("R4 code after restart", ref_code, 10);
    supply_ok = 1'b0; mark();
    adv_to(2); chk("R9 supply +2 gate", gate_en, 1);
    adv_to(3); chk_out("R9 supply +3", 0, 0, 0);

    // R8: enable drop during delay keeps gates off
    supply_ok = 1'b1; mark(); adv_to(10);
    enable = 1'b0; mark(); adv_to(10);
    enable = 1'b1; mark(); adv_to(500);
    enable = 1'b0; mark(); adv_to(1500);
    chk_out("R8 drop in delay", 0, 0, 0);

    finished = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end
endmodule